// File: doc/BRIEF.md
# Low-Side Switch Enable Controller

This block decides when two low-side load switches may conduct. Software sets the wanted on/off state of each switch in a serial command word. The word takes effect only when the serial frame closes with a valid length. The block then gates that wanted state against three conditions: the safety lockout that follows every reset, the supply undervoltage comparator and the thermal shutdown comparator. The gated result drives the two gate-enable outputs.

The block also builds the status and diagnosis portion of the serial response word. It reports the real (gated) state of each switch, along with registered copies of the undervoltage, thermal prewarning and thermal shutdown flags. After each reset the switches stay locked off until the watchdog logic has reported two correctly timed triggers. The asynchronous reset input is released inside the block through a two-stage synchronizer.

Top module: `lsw_ctrl`

## Requirements
- R1: While reset is asserted, and for the two clock edges after its release, `gate_en` is 0, `resp_word` is all zeros and the stored command and trigger count are cleared.
- R2: On a clock edge where `cs_rise` and `frame_ok` are both high, command bit 5 of `spi_word` is stored for switch 1 (`gate_en[0]`) and bit 6 for switch 2 (`gate_en[1]`). The gate output follows on the next clock edge.
- R3: A `cs_rise` with `frame_ok` low leaves the stored command unchanged.
- R4: Changes on `spi_word` without `cs_rise` leave the stored command unchanged.
- R5: After reset, both gates stay off through the first `wdg_ok` pulse. They follow the stored command from the clock edge after the edge that samples the second pulse.
- R6: The trigger count saturates at two: further `wdg_ok` pulses keep the switches released.
- R7: On each edge that samples `uv_flag` high, both gates turn off, and `resp_word` bit 3 reports the flag.
- R8: On each edge that samples `tsd_flag` high, both gates turn off, and `resp_word` bit 14 reports the flag. When the flag clears, the stored command applies again.
- R9: `tpw_flag` is reported on `resp_word` bit 4 and has no effect on the gates.
- R10: `resp_word` bits 5 and 6 equal `gate_en[0]` and `gate_en[1]`, so a commanded but locked-out switch reads 0. All bits other than 3, 4, 5, 6 and 14 read 0.
- R11: Each diagnosis bit shows the flag value sampled at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_word | input | 16 | Decoded serial command word |
| cs_rise | input | 1 | One-cycle strobe at chip-select low-to-high |
| frame_ok | input | 1 | Frame length of the closing word is valid |
| wdg_ok | input | 1 | One-cycle pulse per correct watchdog trigger |
| uv_flag | input | 1 | Supply undervoltage comparator |
| tpw_flag | input | 1 | Thermal prewarning comparator |
| tsd_flag | input | 1 | Thermal shutdown comparator |
| gate_en | output | 2 | Gate enables, bit 0 = switch 1, bit 1 = switch 2 |
| resp_word | output | 16 | Status and diagnosis bits of the serial response |

## Verification
A command load and the second watchdog trigger can fall on the same edge. Either of them can also coincide with an undervoltage or shutdown flag, so the gate result depends on old and new state at once. The random phase raises strobes, triggers and flags independently each cycle, so these collisions occur many times. Each one is judged against a cycle model that uses the pre-edge command, count and flags. Directed steps pin the cases where the release edge and a lockout flag meet the gate update.

// File: rtl/lsw_pkg.sv
package lsw_pkg;
  parameter int unsigned WORD_W       = 16;
  parameter int unsigned N_SW         = 2;
  parameter int unsigned UNLOCK_TRIGS = 2;
  parameter int unsigned CMD_LSB      = 5;
  parameter int unsigned STAT_LSB     = 5;
  parameter int unsigned DIAG_UV_POS  = 3;
  parameter int unsigned DIAG_TPW_POS = 4;
  parameter int unsigned DIAG_TSD_POS = 14;
  localparam int unsigned CNT_W       = $clog2(UNLOCK_TRIGS + 1);

  typedef struct packed {
    logic tsd;
    logic tpw;
    logic uv;
  } diag_t;
endpackage

// File: rtl/lsw_rst_sync.sv
module lsw_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/lsw_cmd_reg.sv
module lsw_cmd_reg #(
  parameter int unsigned WORD_W  = lsw_pkg::WORD_W,
  parameter int unsigned N_SW    = lsw_pkg::N_SW,
  parameter int unsigned CMD_LSB = lsw_pkg::CMD_LSB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] spi_word,
  input  logic              cs_rise,
  input  logic              frame_ok,
  output logic [N_SW-1:0]   cmd_q
);
  logic            load_en;
  logic [N_SW-1:0] cmd_d;

  always_comb begin
    load_en = cs_rise && frame_ok;
    cmd_d   = spi_word[CMD_LSB +: N_SW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cmd_q <= '0;
    else if (load_en) cmd_q <= cmd_d;
  end

  AST_CMD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && frame_ok) |=> (cmd_q == $past(spi_word[CMD_LSB +: N_SW])))
    else $error("command not stored on valid frame close"); // R2

  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(cs_rise && frame_ok) |=> $stable(cmd_q))
    else $error("command changed without a valid frame close"); // R3
endmodule

// File: rtl/lsw_unlock.sv
module lsw_unlock #(
  parameter int unsigned UNLOCK_TRIGS = lsw_pkg::UNLOCK_TRIGS,
  parameter int unsigned CNT_W        = lsw_pkg::CNT_W
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wdg_ok,
  output logic released
);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(UNLOCK_TRIGS);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = wdg_ok && (cnt_q != LIMIT);
    cnt_d  = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign released = (cnt_q == LIMIT);

  AST_UNLOCK_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    (released && wdg_ok) |=> released)
    else $error("release lost on extra trigger"); // R6

  AST_UNLOCK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wdg_ok |=> $stable(cnt_q))
    else $error("trigger count moved without a trigger"); // R5
endmodule

// File: rtl/lsw_gate.sv
module lsw_gate #(
  parameter int unsigned N_SW = lsw_pkg::N_SW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_SW-1:0]      cmd,
  input  logic                 released,
  input  logic                 uv_flag,
  input  logic                 tpw_flag,
  input  logic                 tsd_flag,
  output logic [N_SW-1:0]      gate_q,
  output lsw_pkg::diag_t       diag_q
);
  logic           allow;
  lsw_pkg::diag_t diag_d;

  always_comb begin
    allow      = released && !uv_flag && !tsd_flag;
    diag_d.uv  = uv_flag;
    diag_d.tpw = tpw_flag;
    diag_d.tsd = tsd_flag;
  end

  for (genvar s = 0; s < N_SW; s++) begin : g_sw
    logic on_d;
    always_comb begin
      on_d = cmd[s] && allow;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) gate_q[s] <= 1'b0;
      else        gate_q[s] <= on_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) diag_q <= '0;
    else        diag_q <= diag_d;
  end

  AST_UV_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    uv_flag |=> (gate_q == '0))
    else $error("gate on during undervoltage"); // R7

  AST_TSD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    tsd_flag |=> (gate_q == '0))
    else $error("gate on during thermal shutdown"); // R8

  AST_LOCK_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !released |=> (gate_q == '0))
    else $error("gate on before release"); // R5

  AST_TPW_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    (released && !uv_flag && !tsd_flag) |=> (gate_q == $past(cmd)))
    else $error("gate differs from command while allowed"); // R9
endmodule

// File: rtl/lsw_ctrl.sv
module lsw_ctrl #(
  parameter int unsigned WORD_W = lsw_pkg::WORD_W,
  parameter int unsigned N_SW   = lsw_pkg::N_SW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] spi_word,
  input  logic              cs_rise,
  input  logic              frame_ok,
  input  logic              wdg_ok,
  input  logic              uv_flag,
  input  logic              tpw_flag,
  input  logic              tsd_flag,
  output logic [N_SW-1:0]   gate_en,
  output logic [WORD_W-1:0] resp_word
);
  logic            rst_int_n;
  logic [N_SW-1:0] cmd_q;
  logic            released;
  lsw_pkg::diag_t  diag_q;

  lsw_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  lsw_cmd_reg #(.WORD_W(WORD_W), .N_SW(N_SW), .CMD_LSB(lsw_pkg::CMD_LSB)) u_cmd (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .spi_word (spi_word),
    .cs_rise  (cs_rise),
    .frame_ok (frame_ok),
    .cmd_q    (cmd_q)
  );

  lsw_unlock #(.UNLOCK_TRIGS(lsw_pkg::UNLOCK_TRIGS), .CNT_W(lsw_pkg::CNT_W)) u_unlock (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .wdg_ok   (wdg_ok),
    .released (released)
  );

  lsw_gate #(.N_SW(N_SW)) u_gate (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .cmd      (cmd_q),
    .released (released),
    .uv_flag  (uv_flag),
    .tpw_flag (tpw_flag),
    .tsd_flag (tsd_flag),
    .gate_q   (gate_en),
    .diag_q   (diag_q)
  );

  always_comb begin
    resp_word                              = '0;
    resp_word[lsw_pkg::STAT_LSB +: N_SW]   = gate_en;
    resp_word[lsw_pkg::DIAG_UV_POS]        = diag_q.uv;
    resp_word[lsw_pkg::DIAG_TPW_POS]       = diag_q.tpw;
    resp_word[lsw_pkg::DIAG_TSD_POS]       = diag_q.tsd;
  end

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_int_n |-> (gate_en == '0 && resp_word == '0))
    else $error("outputs active in reset"); // R1
endmodule

// File: tb/lsw_ctrl_tb_top.sv
module lsw_ctrl_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam int  MAX_CYCLES = 200000;
  localparam int  RAND_STEPS = 3000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] spi_word;
  logic        cs_rise, frame_ok, wdg_ok, uv_flag, tpw_flag, tsd_flag;
  logic [1:0]  gate_en;
  logic [15:0] resp_word;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // cycle model
  logic [1:0] m_rs = 2'b00;
  logic [1:0] m_cmd = 2'b00;
  int         m_cnt = 0;
  logic [1:0] m_gate = 2'b00;
  logic       m_uv = 1'b0, m_tpw = 1'b0, m_tsd = 1'b0;
  string      m_tag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  lsw_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .spi_word(spi_word), .cs_rise(cs_rise),
    .frame_ok(frame_ok), .wdg_ok(wdg_ok), .uv_flag(uv_flag),
    .tpw_flag(tpw_flag), .tsd_flag(tsd_flag),
    .gate_en(gate_en), .resp_word(resp_word)
  );

  function automatic logic [1:0] gate_next(logic [1:0] cmd, int cnt, logic uv, logic tsd);
    return (cnt >= 2 && !uv && !tsd) ? cmd : 2'b00;
  endfunction

  function automatic logic [15:0] resp_exp(logic [1:0] g, logic uv, logic tpw, logic tsd);
    logic [15:0] r;
    r = 16'h0000;
    r[6:5] = g;
    r[3] = uv;
    r[4] = tpw;
    r[14] = tsd;
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rst_n || !m_rs[1]) begin
      m_cmd = 2'b00; m_cnt = 0; m_gate = 2'b00;
      m_uv = 1'b0; m_tpw = 1'b0; m_tsd = 1'b0; m_tag = "R1";
    end else begin
      if (m_cnt < 2)   m_tag = "R5";
      else if (uv_flag)  m_tag = "R7";
      else if (tsd_flag) m_tag = "R8";
      else               m_tag = "R2";
      m_gate = gate_next(m_cmd, m_cnt, uv_flag, tsd_flag);
      if (cs_rise && frame_ok) m_cmd = spi_word[6:5];
      if (wdg_ok && m_cnt < 2) m_cnt = m_cnt + 1;
      m_uv = uv_flag; m_tpw = tpw_flag; m_tsd = tsd_flag;
    end
    m_rs = rst_n ? {m_rs[0], 1'b1} : 2'b00;
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > MAX_CYCLES) begin
      errors++;
      $display("FAIL watchdog: run exceeded %0d cycles", MAX_CYCLES);
      finish_run();
    end
  end

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  task automatic cmp_model();
    logic [15:0] r;
    r = resp_exp(m_gate, m_uv, m_tpw, m_tsd);
    chk(m_tag, {14'h0, gate_en}, {14'h0, m_gate});
    chk("R7", {15'h0, resp_word[3]}, {15'h0, r[3]});
    chk("R9", {15'h0, resp_word[4]}, {15'h0, r[4]});
    chk("R8", {15'h0, resp_word[14]}, {15'h0, r[14]});
    chk("R10", resp_word, r);
  endtask

  task automatic drive(logic rst, logic [15:0] w, logic cs, logic fok,
                       logic wdg, logic uv, logic tpw, logic tsd);
    rst_n = rst; spi_word = w; cs_rise = cs; frame_ok = fok;
    wdg_ok = wdg; uv_flag = uv; tpw_flag = tpw; tsd_flag = tsd;
    @(negedge clk);
    cmp_model();
  endtask

  task automatic idle();
    drive(1'b1, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic cmd_word(logic [15:0] w);
    drive(1'b1, w, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic trig();
    drive(1'b1, 16'h0000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic do_reset();
    drive(1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    drive(1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    idle(); idle(); idle();
  endtask

  initial begin
    rst_n = 1'b0; spi_word = '0; cs_rise = 0; frame_ok = 0;
    wdg_ok = 0; uv_flag = 0; tpw_flag = 0; tsd_flag = 0;
    void'($urandom(32'd7411));
    @(negedge clk);

    // R1: reset state
    drive(1'b0, 16'hFFFF, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
    chk("R1", {14'h0, gate_en}, 16'h0000);
    chk("R1", resp_word, 16'h0000);
    idle(); idle(); idle();

    // R5: one trigger is not enough
    cmd_word(16'h0060);
    trig(); idle();
    chk("R5", {14'h0, gate_en}, 16'h0000);
    chk("R10", resp_word, 16'h0000);
    trig();
    chk("R5", {14'h0, gate_en}, 16'h0000);
    idle();
    chk("R5", {14'h0, gate_en}, 16'h0003);
    chk("R10", resp_word, 16'h0060);

    // R3: invalid frame ignored
    drive(1'b1, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    idle();
    chk("R3", {14'h0, gate_en}, 16'h0003);

    // R4: word change without strobe ignored
    drive(1'b1, 16'h0000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    idle();
    chk("R4", {14'h0, gate_en}, 16'h0003);

    // R2: switch 1 only, one cycle of latency after the latching edge
    cmd_word(16'h0020);
    chk("R2", {14'h0, gate_en}, 16'h0003);
    idle();
    chk("R2", {14'h0, gate_en}, 16'h0001);

    // R6: extra triggers keep the release
    trig(); trig(); trig(); idle();
    chk("R6", {14'h0, gate_en}, 16'h0001);

    // R7 / R11: undervoltage
    drive(1'b1, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    chk("R7", {14'h0, gate_en}, 16'h0000);
    chk("R11", resp_word, 16'h0008);
    idle();
    chk("R7", {14'h0, gate_en}, 16'h0001);
    chk("R11", resp_word, 16'h0020);

    // R8: thermal shutdown and recovery
    drive(1'b1, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    drive(1'b1, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R8", {14'h0, gate_en}, 16'h0000);
    chk("R8", resp_word, 16'h4000);
    idle();
    chk("R8", {14'h0, gate_en}, 16'h0001);

    // R9: prewarning leaves gates alone
    drive(1'b1, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    drive(1'b1, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    chk("R9", {14'h0, gate_en}, 16'h0001);
    chk("R9", resp_word, 16'h0030);

    // R10: commanded but locked out reads as off
    do_reset();
    cmd_word(16'h0040); idle(); idle();
    chk("R10", resp_word, 16'h0000);
    chk("R10", {14'h0, gate_en}, 16'h0000);

    // random phase
    for (int i = 0; i < RAND_STEPS; i++) begin
      logic r;
      r = ($urandom_range(0, 199) != 0);
      drive(r, 16'($urandom()), ($urandom_range(0, 7) == 0),
            ($urandom_range(0, 3) != 0), ($urandom_range(0, 19) == 0),
            ($urandom_range(0, 15) == 0), ($urandom_range(0, 3) == 0),
            ($urandom_range(0, 15) == 0));
    end

    finish_run();
  end
endmodule